// File: doc/BRIEF.md
# Multistage Omega Switching Network

This block moves fixed-size packets from P input lanes to P output lanes through a chain of log2(P) identical stages. In front of each stage the P lanes are re-wired by a perfect shuffle, which sends lane i to the lane whose index is i rotated left by one bit. The stage then pairs adjacent lanes in P/2 two-by-two switches. Each switch is either straight (pass) or swapped (cross). The choice comes from one bit of the packet's source tag and the same bit of its destination tag, so no central controller is needed. The result is a path of cost P/2 × log2(P) switches between any source and any destination, instead of the P × P crosspoints of a full crossbar.

Every lane carries a valid bit, a source tag (the index of the input lane that presents it), a destination tag and a data payload. Each stage ends in a register, so a packet takes exactly log2(P) register stages to cross. The network cannot refuse traffic and has no ready signal. A new group of packets may enter on every clock, and there is no back-pressure. If two valid packets at one switch need opposite settings, the packet on the switch's upper (even) lane keeps its path and the other one is discarded. The stage that discarded it raises its blocked flag for one cycle.

Top module: `omega_net`

## Requirements
- R1: While rst_n is low, and after its release until a packet arrives, out_valid and stage_blocked are all zero.
- R2: A group of packets captured on a rising edge appears at the outputs on the log2(P)-th rising edge counting the capturing edge. It is present for that one cycle only. Outputs are empty on every cycle in between.
- R3: A delivered packet appears on the output lane whose index equals its destination tag. Its source tag, destination tag and payload are unchanged.
- R4: Stage k (k = 0 first) compares bit log2(P)-1-k of source and destination and sets its switch to pass when they match and to cross when they differ. Any single packet reaches its destination, including source 2 to destination 7 and source 6 to destination 5 with P = 8.
- R5: Permutations that need no shared switch output, such as identity and every cyclic shift of lane indices, deliver all P packets with no blocked flag raised.
- R6: When two valid packets meet at one switch and need opposite settings, the packet on the even lane of the pair survives and the other is dropped. stage_blocked[k] is high for exactly the one cycle in which that group occupies stage k, which is the (k+1)-th rising edge counting the capture edge.
- R7: Groups presented on consecutive clocks are routed independently and emerge on consecutive clocks. There is no ready signal and no stall.
- R8: An input lane with valid low contributes nothing to any output, whatever its tags and payload hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | P | One valid bit per input lane |
| in_src | input | P*log2(P) | Source tag per lane, lane i in bits [i*log2(P) +: log2(P)], equal to i |
| in_dst | input | P*log2(P) | Destination tag per lane, same packing |
| in_data | input | P*DATA_W | Payload per lane, lane i in bits [i*DATA_W +: DATA_W] |
| out_valid | output | P | One valid bit per output lane |
| out_src | output | P*log2(P) | Source tag of the packet on each output lane |
| out_dst | output | P*log2(P) | Destination tag of the packet on each output lane |
| out_data | output | P*DATA_W | Payload of the packet on each output lane |
| stage_blocked | output | log2(P) | Bit k high when stage k dropped a packet of the group it holds |

## Verification
A switch that takes the wrong bit, or the wrong setting, sends a packet to an output lane that differs from its destination tag. This shows log2(P) cycles after capture, on the very cycle the packet emerges. A shuffle miswired or a missing register shows as packets arriving one cycle early or late, or on the wrong lane. A wrong winner in a conflict shows as the wrong source tag on the shared output. The blocked flag of the stage concerned is compared on every cycle the group is in flight, so a flag on the wrong stage or cycle is caught at the cycle it appears. A full sweep of single packets over every source and destination pair covers each switch setting in every stage.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic {
    SW_PASS  = 1'b0,
    SW_CROSS = 1'b1
  } sw_mode_e;

  // Straight when the two tag bits agree, swapped when they differ.
  function automatic sw_mode_e pick_mode(input logic src_bit, input logic dst_bit);
    return (src_bit ^ dst_bit) ? SW_CROSS : SW_PASS;
  endfunction

endpackage

// File: rtl/omega_shuffle.sv
module omega_shuffle #(
  parameter int P = 8,
  parameter int W = 16
) (
  input  logic [P*W-1:0] lines_i,
  output logic [P*W-1:0] lines_o
);

  localparam int HALF = P / 2;

  // Lane i moves to lane rotl(i): low bits shift up, the top bit wraps to bit 0.
  for (genvar i = 0; i < P; i++) begin : g_lane
    localparam int DST = ((i * 2) % P) + (i / HALF);
    assign lines_o[DST*W +: W] = lines_i[i*W +: W];
  end

endmodule

// File: rtl/omega_switch2.sv
module omega_switch2
  import omega_pkg::*;
#(
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int BIT = 0,
  localparam int PW = 1 + 2 * AW + DW
) (
  input  logic [PW-1:0] up_i,
  input  logic [PW-1:0] lo_i,
  output logic [PW-1:0] out0_o,
  output logic [PW-1:0] out1_o,
  output logic          conflict_o
);

  localparam int VB      = PW - 1;
  localparam int SRC_LSB = DW + AW;
  localparam int DST_LSB = DW;

  sw_mode_e        up_mode;
  sw_mode_e        lo_mode;
  sw_mode_e        mode;
  logic [PW-1:0]   lo_keep;

  always_comb begin
    up_mode    = pick_mode(up_i[SRC_LSB+BIT], up_i[DST_LSB+BIT]);
    lo_mode    = pick_mode(lo_i[SRC_LSB+BIT], lo_i[DST_LSB+BIT]);
    conflict_o = up_i[VB] & lo_i[VB] & (up_mode != lo_mode);
    lo_keep    = lo_i;
    if (conflict_o) lo_keep[VB] = 1'b0;
    mode = up_i[VB] ? up_mode : lo_mode;
    if (mode == SW_PASS) begin
      out0_o = up_i;
      out1_o = lo_keep;
    end else begin
      out0_o = lo_keep;
      out1_o = up_i;
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int P   = 8,
  parameter int AW  = 3,
  parameter int DW  = 8,
  parameter int BIT = 0,
  localparam int PW = 1 + 2 * AW + DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P*PW-1:0] lines_i,
  output logic [P*PW-1:0] lines_o,
  output logic            blocked_o
);

  localparam int NSW = P / 2;

  logic [P*PW-1:0] sh_lines;
  logic [P*PW-1:0] sw_lines;
  logic [NSW-1:0]  conflicts;

  omega_shuffle #(.P(P), .W(PW)) u_shuffle (
    .lines_i (lines_i),
    .lines_o (sh_lines)
  );

  for (genvar j = 0; j < NSW; j++) begin : g_sw
    omega_switch2 #(.AW(AW), .DW(DW), .BIT(BIT)) u_sw (
      .up_i       (sh_lines[(2*j)*PW +: PW]),
      .lo_i       (sh_lines[(2*j+1)*PW +: PW]),
      .out0_o     (sw_lines[(2*j)*PW +: PW]),
      .out1_o     (sw_lines[(2*j+1)*PW +: PW]),
      .conflict_o (conflicts[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_o   <= '0;
      blocked_o <= 1'b0;
    end else begin
      lines_o   <= sw_lines;
      blocked_o <= |conflicts;
    end
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int P      = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(P)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P-1:0]        in_valid,
  input  logic [P*ADDR_W-1:0] in_src,
  input  logic [P*ADDR_W-1:0] in_dst,
  input  logic [P*DATA_W-1:0] in_data,
  output logic [P-1:0]        out_valid,
  output logic [P*ADDR_W-1:0] out_src,
  output logic [P*ADDR_W-1:0] out_dst,
  output logic [P*DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0]   stage_blocked
);

  localparam int NSTG = ADDR_W;
  localparam int PW   = 1 + 2 * ADDR_W + DATA_W;

  logic [P*PW-1:0] bus [NSTG+1];

  // Pack each lane as {valid, src, dst, data}.
  for (genvar i = 0; i < P; i++) begin : g_pack
    assign bus[0][i*PW +: PW] = {in_valid[i], in_src[i*ADDR_W +: ADDR_W],
                                 in_dst[i*ADDR_W +: ADDR_W], in_data[i*DATA_W +: DATA_W]};
  end

  // Stage k resolves tag bit ADDR_W-1-k (most significant first).
  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    omega_stage #(.P(P), .AW(ADDR_W), .DW(DATA_W), .BIT(NSTG-1-k)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines_i   (bus[k]),
      .lines_o   (bus[k+1]),
      .blocked_o (stage_blocked[k])
    );
  end

  for (genvar i = 0; i < P; i++) begin : g_unpack
    assign out_valid[i]                  = bus[NSTG][i*PW + PW - 1];
    assign out_src[i*ADDR_W +: ADDR_W]   = bus[NSTG][i*PW + DATA_W + ADDR_W +: ADDR_W];
    assign out_dst[i*ADDR_W +: ADDR_W]   = bus[NSTG][i*PW + DATA_W +: ADDR_W];
    assign out_data[i*DATA_W +: DATA_W]  = bus[NSTG][i*PW +: DATA_W];
  end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int P  = 8,
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [P-1:0]     in_valid,
  input logic [P-1:0]     out_valid,
  input logic [P*AW-1:0]  out_dst,
  input logic [AW-1:0]    stage_blocked
);

  localparam int CW = AW + 1;

  // Packet count of each in-flight group, and whether any stage dropped from it yet.
  logic [CW-1:0] cnt_q   [AW];
  logic          clean_q [AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < AW; k++) begin
        cnt_q[k]   <= '0;
        clean_q[k] <= 1'b1;
      end
    end else begin
      cnt_q[0]   <= CW'($countones(in_valid));
      clean_q[0] <= 1'b1;
      for (int k = 1; k < AW; k++) begin
        cnt_q[k]   <= cnt_q[k-1];
        clean_q[k] <= clean_q[k-1] & ~stage_blocked[k-1];
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (out_valid == '0 && stage_blocked == '0)); // R1

  AST_LOSSLESS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_q[AW-1] && !stage_blocked[AW-1]) |-> ($countones(out_valid) == int'(cnt_q[AW-1]))); // R2

  AST_BLOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clean_q[AW-1] || stage_blocked[AW-1]) |-> ($countones(out_valid) < int'(cnt_q[AW-1]))); // R6

  for (genvar j = 0; j < P; j++) begin : g_home
    AST_DELIVERED_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[j] |-> (out_dst[j*AW +: AW] == AW'(j))); // R3
  end

endmodule

bind omega_net omega_net_chk #(.P(P), .AW(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .out_dst       (out_dst),
  .stage_blocked (stage_blocked)
);

// File: tb/omega_net_bench.sv
module omega_net_bench;

  localparam int P          = 8;
  localparam int AW         = 3;
  localparam int DW         = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [P-1:0]    in_valid;
  logic [P*AW-1:0] in_src;
  logic [P*AW-1:0] in_dst;
  logic [P*DW-1:0] in_data;
  logic [P-1:0]    out_valid;
  logic [P*AW-1:0] out_src;
  logic [P*AW-1:0] out_dst;
  logic [P*DW-1:0] out_data;
  logic [AW-1:0]   stage_blocked;

  omega_net #(.P(P), .DATA_W(DW)) u_omega_net (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst), .in_data(in_data),
    .out_valid(out_valid), .out_src(out_src), .out_dst(out_dst), .out_data(out_data),
    .stage_blocked(stage_blocked)
  );

  int n_chk  = 0;
  int n_fail = 0;

  logic          tv_v [P];
  logic [AW-1:0] tv_d [P];
  logic [DW-1:0] tv_x [P];
  logic [P-1:0]  tv_lost;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_tv();
    for (int i = 0; i < P; i++) begin
      tv_v[i] = 1'b0; tv_d[i] = '0; tv_x[i] = '0;
    end
    tv_lost = '0;
  endtask

  task automatic drive_idle();
    in_valid = '0; in_dst = '0; in_data = '0;
    for (int i = 0; i < P; i++) in_src[i*AW +: AW] = AW'(i);
  endtask

  task automatic drive_tv();
    for (int i = 0; i < P; i++) begin
      in_valid[i]          = tv_v[i];
      in_src[i*AW +: AW]   = AW'(i);
      in_dst[i*AW +: AW]   = tv_d[i];
      in_data[i*DW +: DW]  = tv_x[i];
    end
  endtask

  // Compare every output lane against the packets of tv that should survive.
  task automatic check_outputs(input string req);
    logic [P-1:0]  ev;
    logic [AW-1:0] es [P];
    logic [DW-1:0] ex [P];
    ev = '0;
    for (int j = 0; j < P; j++) begin es[j] = '0; ex[j] = '0; end
    for (int i = 0; i < P; i++) begin
      if (tv_v[i] && !tv_lost[i]) begin
        ev[tv_d[i]] = 1'b1; es[tv_d[i]] = AW'(i); ex[tv_d[i]] = tv_x[i];
      end
    end
    check(out_valid == ev, req, "output valid lanes", 64'(out_valid), 64'(ev));
    for (int j = 0; j < P; j++) begin
      if (ev[j]) begin
        check({out_src[j*AW +: AW], out_dst[j*AW +: AW], out_data[j*DW +: DW]} ==
              {es[j], AW'(j), ex[j]}, req, $sformatf("lane %0d packet", j),
              64'({out_src[j*AW +: AW], out_dst[j*AW +: AW], out_data[j*DW +: DW]}),
              64'({es[j], AW'(j), ex[j]}));
      end
    end
  endtask

  // One group: capture, watch each stage cycle, then confirm the group is gone.
  task automatic run_group(input string req, input logic [AW-1:0] exp_blk);
    @(negedge clk); drive_tv();
    for (int s = 0; s < AW; s++) begin
      @(negedge clk);
      if (s == 0) drive_idle();
      check(stage_blocked == (exp_blk & AW'(1 << s)), req,
            $sformatf("blocked after edge %0d", s + 1),
            64'(stage_blocked), 64'(exp_blk & AW'(1 << s)));
      if (s < AW - 1)
        check(out_valid == '0, "R2", "early output", 64'(out_valid), 64'(0));
      else
        check_outputs(req);
    end
    @(negedge clk);
    check(out_valid == '0 && stage_blocked == '0, "R2", "group lingers",
          64'({out_valid, stage_blocked}), 64'(0));
  endtask

  task automatic t_reset();
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == '0 && stage_blocked == '0, "R1", "in reset",
          64'({out_valid, stage_blocked}), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == '0 && stage_blocked == '0, "R1", "after release",
          64'({out_valid, stage_blocked}), 64'(0));
  endtask

  task automatic t_stated_routes();
    clear_tv(); tv_v[2] = 1'b1; tv_d[2] = 3'd7; tv_x[2] = 8'h27;
    run_group("R4", '0);
    clear_tv(); tv_v[6] = 1'b1; tv_d[6] = 3'd5; tv_x[6] = 8'h65;
    run_group("R4", '0);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < P; s++) begin
      for (int d = 0; d < P; d++) begin
        clear_tv(); tv_v[s] = 1'b1; tv_d[s] = AW'(d); tv_x[s] = DW'(s * 16 + d);
        run_group("R4", '0);
      end
    end
  endtask

  task automatic t_shifts();
    for (int k = 0; k < P; k++) begin
      clear_tv();
      for (int i = 0; i < P; i++) begin
        tv_v[i] = 1'b1; tv_d[i] = AW'((i + k) % P); tv_x[i] = DW'(8'h5A ^ (i * 9 + k));
      end
      run_group("R5", '0);
    end
  endtask

  task automatic t_conflicts();
    // Stage 0: lanes 0 and 4 share the first switch; lane 0 is the even input.
    clear_tv();
    tv_v[0] = 1'b1; tv_d[0] = 3'd2; tv_x[0] = 8'hC0;
    tv_v[4] = 1'b1; tv_d[4] = 3'd0; tv_x[4] = 8'hC4;
    tv_lost[4] = 1'b1;
    run_group("R6", 3'b001);
    // Stage 1: sources 0 and 2 meet; source 0 arrives on the even lane.
    clear_tv();
    tv_v[0] = 1'b1; tv_d[0] = 3'd1; tv_x[0] = 8'hD0;
    tv_v[2] = 1'b1; tv_d[2] = 3'd0; tv_x[2] = 8'hD2;
    tv_lost[2] = 1'b1;
    run_group("R6", 3'b010);
    // Stage 2: sources 0 and 1 both head for lane 0 and meet last.
    clear_tv();
    tv_v[0] = 1'b1; tv_d[0] = 3'd0; tv_x[0] = 8'hE0;
    tv_v[1] = 1'b1; tv_d[1] = 3'd0; tv_x[1] = 8'hE1;
    tv_lost[1] = 1'b1;
    run_group("R6", 3'b100);
  endtask

  task automatic t_invalid_lanes();
    // Lanes with valid low carry tags that would collide; nothing may appear or block.
    clear_tv();
    for (int i = 0; i < P; i++) begin
      tv_d[i] = 3'd0; tv_x[i] = 8'hF0 + DW'(i);
    end
    tv_v[3] = 1'b1; tv_d[3] = 3'd6;
    run_group("R8", '0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    clear_tv();
    for (int i = 0; i < P; i++) begin tv_v[i] = 1'b1; tv_d[i] = AW'(i); tv_x[i] = DW'(8'h10 + i); end
    drive_tv();
    @(negedge clk);
    for (int i = 0; i < P; i++) begin tv_d[i] = AW'((i + 3) % P); tv_x[i] = DW'(8'h20 + i); end
    drive_tv();
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    for (int i = 0; i < P; i++) begin tv_d[i] = AW'(i); tv_x[i] = DW'(8'h10 + i); end
    check_outputs("R7");
    @(negedge clk);
    for (int i = 0; i < P; i++) begin tv_d[i] = AW'((i + 3) % P); tv_x[i] = DW'(8'h20 + i); end
    check_outputs("R7");
    @(negedge clk);
    check(out_valid == '0, "R7", "after burst", 64'(out_valid), 64'(0));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_stated_routes();
    t_sweep();
    t_shifts();
    t_conflicts();
    t_invalid_lanes();
    t_back_to_back();
    finish_run();
  end

endmodule